// File: doc/BRIEF.md
# Two-Bank Row Activation Timing Monitor

This block sits passively on the command pins of a two-bank synchronous DRAM and follows every clock edge. It decodes row activation, column reads and writes, and precharge. From these commands it tracks which bank has a row open and which row that is. It also checks the command stream against three spacing limits:

- the wait from opening a row to the first column access;
- the minimum period between two openings of the same bank;
- the minimum gap between openings of the two different banks.

All three limits are given in clock cycles as parameters.

Each kind of misuse sets its own sticky bit in a violation code. There are five kinds: access to a closed bank, reopening an open bank, and a breach of each of the three spacing limits. A bit stays set until a synchronous clear. The block never drives the command bus. It is intended for a controller's self-check logic or for a protocol monitor beside a memory model.

Top module: `bank_act_monitor`

## Requirements
- R1: An activate (csN=0, rasN=0, casN=1, weN=1) opens the bank chosen by addr[11] (0 = bank 0, 1 = bank 1), and records addr[10:0] as that bank's row on rowBank0 or rowBank1. The result is visible after that clock edge.
- R2: A precharge (csN=0, rasN=0, casN=1, weN=0) closes both banks when addr[10]=1. When addr[10]=0 it closes only the bank chosen by addr[11].
- R3: A read (csN=0, rasN=1, casN=0, weN=1) or a write (csN=0, rasN=1, casN=0, weN=0) to a closed bank sets violCode bit 0.
- R4: An activate to a bank that is already open sets violCode bit 1. The activate still takes effect and records the new row.
- R5: A read or write to an open bank fewer than RCD_CYC cycles after that bank's activate sets violCode bit 2. At exactly RCD_CYC cycles no bit is set.
- R6: An activate fewer than RC_CYC cycles after the previous activate to the same bank sets violCode bit 3. At exactly RC_CYC cycles no bit is set.
- R7: An activate fewer than RRD_CYC cycles after an activate to the other bank sets violCode bit 4, in either order of banks. At exactly RRD_CYC cycles no bit is set.
- R8: A cycle with csN=1, or with rasN, casN and weN all high, changes neither the bank state nor the violation code.
- R9: Violation bits are sticky until violClear=1 at a clock edge. Clearing zeroes every bit except those that are newly set in that same cycle. violAny is the OR of all violCode bits.
- R10: Reset closes both banks, zeroes violCode and leaves every timer expired. An activate to either bank directly after reset therefore flags nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 12 | Bit 11 selects the bank, bits 10:0 carry the row, bit 10 is the all-bank flag on precharge |
| violClear | input | 1 | Synchronous clear of the sticky violation bits |
| bankOpen | output | 2 | Open flag per bank, bit 0 = bank 0 |
| rowBank0 | output | 11 | Row last opened in bank 0 |
| rowBank1 | output | 11 | Row last opened in bank 1 |
| violAny | output | 1 | Any violation bit set |
| violCode | output | 5 | Sticky bits: 0 closed access, 1 reopen, 2 row-to-column, 3 same-bank cycle, 4 bank-to-bank |

## Verification
The assertions are checked on every cycle and cover these behaviours:
- an activate opens its bank and records the row;
- an all-bank precharge closes both banks;
- an access to a closed bank and a reopen of an open bank are each flagged;
- a deselected cycle leaves the open flags alone;
- set bits survive every cycle without a clear.

The three cycle-count limits depend on how many cycles have passed since an earlier command. Only the bench's scenarios show them, by placing commands one cycle short of each limit and exactly on it, in both bank orders. The bench scenarios also show the single-bank precharge and the case where a clear meets a new violation in the same cycle.

// File: rtl/bam_pkg.sv
package bam_pkg;

  // Violation bit positions in the sticky code
  localparam int VIOL_W      = 5;
  localparam int VB_CLOSED   = 0;
  localparam int VB_REOPEN   = 1;
  localparam int VB_RCD      = 2;
  localparam int VB_RC       = 3;
  localparam int VB_RRD      = 4;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_OTHER
  } bamCmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // activate accepted this cycle
    logic bank;   // bank it targets
  } bamStrobe_t;

endpackage

// File: rtl/bam_down_cnt.sv
module bam_down_cnt #(
  parameter int LOAD = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic done
);
  localparam int W = $clog2(LOAD + 2);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt;

  // Saturating down-counter; reset leaves it expired
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= LOAD_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/bam_bank_dp.sv
module bam_bank_dp
  import bam_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int RCD_CYC = 3,
  parameter int RC_CYC  = 7,
  parameter int RRD_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bamStrobe_t             stb,
  input  logic [ROW_W-1:0]       rowIn,
  output logic [1:0][ROW_W-1:0]  openRow,
  output logic [1:0]             rcdDone,
  output logic [1:0]             rcDone,
  output logic                   rrdDone,
  output logic                   lastBank
);
  localparam int NBANK = 2;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = stb.load && (stb.bank == 1'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    openRow[b] <= '0;
      else if (hit) openRow[b] <= rowIn;
    end

    bam_down_cnt #(.LOAD(RCD_CYC - 1)) u_rcd (
      .clk(clk), .rstN(rstN), .load(hit), .done(rcdDone[b])
    );

    bam_down_cnt #(.LOAD(RC_CYC - 1)) u_rc (
      .clk(clk), .rstN(rstN), .load(hit), .done(rcDone[b])
    );
  end

  // One shared window for activates on either bank
  bam_down_cnt #(.LOAD(RRD_CYC - 1)) u_rrd (
    .clk(clk), .rstN(rstN), .load(stb.load), .done(rrdDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastBank <= 1'b0;
    else if (stb.load) lastBank <= stb.bank;
  end
endmodule

// File: rtl/bam_ctrl.sv
module bam_ctrl
  import bam_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic               bankBit,
  input  logic               allBit,
  input  logic               violClear,
  input  logic [1:0]         rcdDone,
  input  logic [1:0]         rcDone,
  input  logic               rrdDone,
  input  logic               lastBank,
  output bamStrobe_t         stb,
  output logic [1:0]         bankOpen,
  output logic [VIOL_W-1:0]  violCode
);
  bamCmd_t cmd;
  logic isAct, isAcc, isPre;
  logic [VIOL_W-1:0] newViol;

  always_comb begin
    if (csN) cmd = CMD_NOP;
    else begin
      unique case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = CMD_PRE;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

  assign isAct = (cmd == CMD_ACT);
  assign isAcc = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign isPre = (cmd == CMD_PRE);

  always_comb begin
    newViol            = '0;
    newViol[VB_CLOSED] = isAcc && !bankOpen[bankBit];
    newViol[VB_RCD]    = isAcc &&  bankOpen[bankBit] && !rcdDone[bankBit];
    newViol[VB_REOPEN] = isAct &&  bankOpen[bankBit];
    newViol[VB_RC]     = isAct && !rcDone[bankBit];
    newViol[VB_RRD]    = isAct && (lastBank != bankBit) && !rrdDone;
  end

  assign stb.load = isAct;
  assign stb.bank = bankBit;

  for (genvar b = 0; b < 2; b++) begin : g_state
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankOpen[b] <= 1'b0;
      else if (isAct && (bankBit == 1'(b)))
        bankOpen[b] <= 1'b1;
      else if (isPre && (allBit || (bankBit == 1'(b))))
        bankOpen[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) violCode <= '0;
    else       violCode <= (violClear ? '0 : violCode) | newViol;
  end
endmodule

// File: rtl/bank_act_monitor.sv
module bank_act_monitor
  import bam_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int RCD_CYC = 3,
  parameter int RC_CYC  = 7,
  parameter int RRD_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic [ROW_W:0]     addr,
  input  logic               violClear,
  output logic [1:0]         bankOpen,
  output logic [ROW_W-1:0]   rowBank0,
  output logic [ROW_W-1:0]   rowBank1,
  output logic               violAny,
  output logic [VIOL_W-1:0]  violCode
);
  bamStrobe_t               stb;
  logic [1:0][ROW_W-1:0]    openRow;
  logic [1:0]               rcdDone, rcDone;
  logic                     rrdDone, lastBank;

  bam_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankBit(addr[ROW_W]), .allBit(addr[ROW_W-1]),
    .violClear(violClear),
    .rcdDone(rcdDone), .rcDone(rcDone), .rrdDone(rrdDone), .lastBank(lastBank),
    .stb(stb), .bankOpen(bankOpen), .violCode(violCode)
  );

  bam_bank_dp #(
    .ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .RRD_CYC(RRD_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowIn(addr[ROW_W-1:0]),
    .openRow(openRow), .rcdDone(rcdDone), .rcDone(rcDone),
    .rrdDone(rrdDone), .lastBank(lastBank)
  );

  assign rowBank0 = openRow[0];
  assign rowBank1 = openRow[1];
  assign violAny  = |violCode;
endmodule

// File: rtl/bank_act_monitor_chk.sv
module bank_act_monitor_chk #(
  parameter int ROW_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ROW_W:0]    addr,
  input logic              violClear,
  input logic [1:0]        bankOpen,
  input logic [ROW_W-1:0]  rowBank0,
  input logic [ROW_W-1:0]  rowBank1,
  input logic [4:0]        violCode
);
  logic actCmd, accCmd, preCmd;
  assign actCmd = !csN && !rasN &&  casN &&  weN;
  assign accCmd = !csN &&  rasN && !casN;
  assign preCmd = !csN && !rasN &&  casN && !weN;

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    actCmd |=> bankOpen[$past(addr[ROW_W])]);                           // R1

  AST_ACT_ROW0: assert property (@(posedge clk) disable iff (!rstN)
    (actCmd && !addr[ROW_W]) |=> rowBank0 == $past(addr[ROW_W-1:0]));  // R1

  AST_ACT_ROW1: assert property (@(posedge clk) disable iff (!rstN)
    (actCmd && addr[ROW_W]) |=> rowBank1 == $past(addr[ROW_W-1:0]));   // R1

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (preCmd && addr[ROW_W-1]) |=> bankOpen == 2'b00);                  // R2

  AST_CLOSED_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (accCmd && !bankOpen[addr[ROW_W]]) |=> violCode[0]);                // R3

  AST_REOPEN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (actCmd && bankOpen[addr[ROW_W]]) |=> violCode[1]);                 // R4

  AST_DESELECT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> bankOpen == $past(bankOpen));                               // R8

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !violClear |=> (violCode & $past(violCode)) == $past(violCode));    // R9
endmodule

bind bank_act_monitor bank_act_monitor_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .addr(addr), .violClear(violClear), .bankOpen(bankOpen),
  .rowBank0(rowBank0), .rowBank1(rowBank1), .violCode(violCode)
);

// File: tb/sim_bank_act_monitor.sv
module sim_bank_act_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [11:0] addr = '0;
  logic        violClear = 1'b0;
  logic [1:0]  bankOpen;
  logic [10:0] rowBank0, rowBank1;
  logic        violAny;
  logic [4:0]  violCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bank_act_monitor u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .violClear(violClear), .bankOpen(bankOpen),
    .rowBank0(rowBank0), .rowBank1(rowBank1), .violAny(violAny), .violCode(violCode)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Apply pins at a falling edge; return at the next falling edge
  task automatic step(input logic c, input logic r, input logic ca, input logic w, input logic [11:0] a);
    csN = c; rasN = r; casN = ca; weN = w; addr = a;
    @(negedge clk);
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'h0);
  endtask
  task automatic act(input logic b, input logic [10:0] row); step(1'b0, 1'b0, 1'b1, 1'b1, {b, row}); endtask
  task automatic rd(input logic b);  step(1'b0, 1'b1, 1'b0, 1'b1, {b, 11'h0}); endtask
  task automatic wr(input logic b);  step(1'b0, 1'b1, 1'b0, 1'b0, {b, 11'h0}); endtask
  task automatic pre(input logic b, input logic all); step(1'b0, 1'b0, 1'b1, 1'b0, {b, all, 10'h0}); endtask
  task automatic clr();
    violClear = 1'b1; idle(1); violClear = 1'b0;
  endtask
  task automatic settle();
    pre(1'b0, 1'b1); idle(8); clr();
  endtask

  task automatic t_reset();
    chk("R10", "bankOpen after reset", 32'(bankOpen), 32'h0);
    chk("R10", "violCode after reset", 32'(violCode), 32'h0);
    act(1'b0, 11'h155);
    chk("R10", "activate right after reset", 32'(violCode), 32'h0);
    chk("R1", "bank0 open", 32'(bankOpen), 32'h1);
    chk("R1", "bank0 row", 32'(rowBank0), 32'h155);
  endtask

  task automatic t_rcd();
    settle();
    act(1'b1, 11'h2AA);
    chk("R1", "bank1 row", 32'(rowBank1), 32'h2AA);
    idle(1); rd(1'b1);                 // gap 2
    chk("R5", "read one short of limit", 32'(violCode), 32'h04);
    clr();                             // gap now 3
    wr(1'b1);
    chk("R5", "write past limit", 32'(violCode), 32'h0);
    settle();
    act(1'b0, 11'h011); idle(2); wr(1'b0);   // exactly 3
    chk("R5", "write at exact limit", 32'(violCode), 32'h0);
  endtask

  task automatic t_closed();
    settle();
    wr(1'b0);
    chk("R3", "write to closed bank0", 32'(violCode), 32'h01);
    chk("R9", "violAny follows code", 32'(violAny), 32'h1);
    clr();
    chk("R9", "clear zeroes code", 32'(violCode), 32'h0);
    rd(1'b1);
    chk("R3", "read to closed bank1", 32'(violCode), 32'h01);
  endtask

  task automatic t_reopen();
    settle();
    act(1'b0, 11'h00F); idle(7); act(1'b0, 11'h0F0);   // gap 8
    chk("R4", "reopen flagged alone", 32'(violCode), 32'h02);
    chk("R4", "row replaced", 32'(rowBank0), 32'h0F0);
    idle(3);
    chk("R9", "bit persists without clear", 32'(violCode), 32'h02);
  endtask

  task automatic t_rc();
    settle();
    act(1'b0, 11'h001); pre(1'b0, 1'b0); idle(4); act(1'b0, 11'h002);  // gap 6
    chk("R6", "same-bank activate one short", 32'(violCode), 32'h08);
    pre(1'b0, 1'b0); clr(); idle(4); act(1'b0, 11'h003);               // gap 7
    chk("R6", "same-bank activate at limit", 32'(violCode), 32'h0);
  endtask

  task automatic t_rrd();
    settle();
    act(1'b0, 11'h010); act(1'b1, 11'h020);
    chk("R7", "bank0 then bank1 gap 1", 32'(violCode), 32'h10);
    settle();
    act(1'b1, 11'h030); act(1'b0, 11'h040);
    chk("R7", "bank1 then bank0 gap 1", 32'(violCode), 32'h10);
    settle();
    act(1'b0, 11'h050); idle(1); act(1'b1, 11'h060);
    chk("R7", "different banks at limit", 32'(violCode), 32'h0);
  endtask

  task automatic t_pre();
    settle();
    act(1'b0, 11'h100); idle(2); act(1'b1, 11'h200);
    pre(1'b1, 1'b0);
    chk("R2", "single-bank precharge of bank1", 32'(bankOpen), 32'h1);
    act(1'b1, 11'h201); idle(7);
    pre(1'b0, 1'b1);
    chk("R2", "all-bank precharge", 32'(bankOpen), 32'h0);
  endtask

  task automatic t_ignore();
    settle();
    step(1'b1, 1'b0, 1'b1, 1'b1, 12'h123);          // deselected activate pattern
    chk("R8", "deselected activate ignored", 32'(bankOpen), 32'h0);
    act(1'b0, 11'h077); idle(7);
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'h400);          // deselected precharge-all
    chk("R8", "deselected precharge ignored", 32'(bankOpen), 32'h1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h400);          // selected, all strobes high
    chk("R8", "strobes high ignored open", 32'(bankOpen), 32'h1);
    chk("R8", "strobes high no violation", 32'(violCode), 32'h0);
  endtask

  task automatic t_clear_race();
    settle();
    act(1'b0, 11'h001); act(1'b1, 11'h002);         // sets bit 4
    pre(1'b0, 1'b1);
    violClear = 1'b1; rd(1'b0); violClear = 1'b0;   // clear meets closed access
    chk("R9", "new bit survives same-cycle clear", 32'(violCode), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rcd();
    t_closed();
    t_reopen();
    t_rc();
    t_rrd();
    t_pre();
    t_ignore();
    t_clear_race();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule